// File: doc/BRIEF.md
# PWM Trip Flag and Interrupt Latch

This block records protection trip events for one PWM channel and turns them into an interrupt request. Two trip inputs arrive already selected and synchronized. One is a one-shot source and the other is a cycle-by-cycle source. Each input sets its own sticky flag. Software can read the flags through a 16-bit flag word and clears them with a write-one-to-clear mask.

The block drives two active-trip indications for the output action logic. The cycle-by-cycle condition is held separately from its flag. It is released only on a time-base-counter-at-zero strobe, and only when the trip input has gone quiet. The one-shot condition lasts until its flag is cleared.

An interrupt flag gates a single-cycle interrupt pulse, and per-source enables choose which flags may raise it. Clearing the interrupt flag while an enabled source flag is still set raises a new pulse. Clearing every flag stops further pulses.

Top module: `pwm_trip_flags`

## Requirements
- R1: `flags_o` is 0 after reset. It carries the interrupt flag at bit 0, the cycle-by-cycle flag at bit 1 and the one-shot flag at bit 2. Bits 15 to 3 always read 0.
- R2: The one-shot flag (bit 2) is 1 from the clock after `ost_trip_i` is sampled high. It stays 1 until a clear write with `clr_mask_i[2]` set.
- R3: The cycle-by-cycle flag (bit 1) is 1 from the clock after `cbc_trip_i` is sampled high. It stays 1 until a clear write with `clr_mask_i[1]` set. A clear applied while `cbc_trip_i` is high leaves it at 1.
- R4: A flag clears only on a clock where `clr_we_i` is 1 and its own mask bit is 1. A mask written with `clr_we_i` at 0 has no effect.
- R5: `cbc_active_o` becomes 1 on the clock after `cbc_trip_i` is high. It returns to 0 only on a clock where `ctr_zero_i` is 1 and `cbc_trip_i` is 0. Clearing the flag does not release it.
- R6: `ost_active_o` equals the one-shot flag. `ctr_zero_i` does not release it.
- R7: `int_pulse_o` is 1 in any cycle where the interrupt flag is 0 and an enabled source flag is 1. The interrupt flag is set on the clock that ends that cycle, so the pulse lasts one cycle.
- R8: A source flag whose enable (`ost_int_en_i` or `cbc_int_en_i`) is 0 raises no pulse. Raising the enable while that flag is set raises one.
- R9: While the interrupt flag is 1, `int_pulse_o` stays 0, even when new trips arrive.
- R10: Clearing only the interrupt flag while an enabled source flag stays set gives a new pulse in the next cycle. Clearing all three flags gives no further pulse.
- R11: When a set and a clear hit the same flag on the same clock, the flag ends up 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ost_trip_i | input | 1 | One-shot trip source, synchronized |
| cbc_trip_i | input | 1 | Cycle-by-cycle trip source, synchronized |
| ctr_zero_i | input | 1 | Time-base counter equals zero strobe |
| ost_int_en_i | input | 1 | One-shot interrupt enable |
| cbc_int_en_i | input | 1 | Cycle-by-cycle interrupt enable |
| clr_we_i | input | 1 | Clear write strobe |
| clr_mask_i | input | 3 | Clear mask: bit 2 one-shot, bit 1 cycle-by-cycle, bit 0 interrupt |
| flags_o | output | 16 | Latched flag word |
| int_pulse_o | output | 1 | Single-cycle interrupt pulse |
| ost_active_o | output | 1 | One-shot trip condition active |
| cbc_active_o | output | 1 | Cycle-by-cycle trip condition active |

## Verification
The bench checks that clearing the cycle-by-cycle flag does not release the trip condition. A design that released on a flag clear, or on a counter-zero strobe while the trip is still high, would drop `cbc_active_o` too early. It also checks that a clear racing a live trip leaves the flag set; a clear-wins design would lose the event. Clearing only the interrupt flag must give a second pulse, so a design without re-fire would go silent. Raising an enable late must give a pulse at once, and a design that missed this would hold back a pending trip.

// File: rtl/pwm_trip_pkg.sv
package pwm_trip_pkg;
  localparam int FLAG_W  = 16;
  localparam int CLR_W   = 3;
  localparam int BIT_INT = 0;
  localparam int BIT_CBC = 1;
  localparam int BIT_OST = 2;
  localparam int NUM_SRC = 2;
  // source index i maps to flag bit i+1
  localparam int SRC_CBC = BIT_CBC - 1;
  localparam int SRC_OST = BIT_OST - 1;
endpackage

// File: rtl/trip_flag_cell.sv
module trip_flag_cell (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic q_o
);
  logic q_q;

  // set dominates clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_q <= 1'b0;
    else         q_q <= set_i | (q_q & ~clr_i);
  end

  assign q_o = q_q;
endmodule

// File: rtl/cbc_cond_hold.sv
module cbc_cond_hold (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic trip_i,
  input  logic zero_i,
  output logic active_o
);
  logic act_q;

  // released only at counter zero with the trip gone
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) act_q <= 1'b0;
    else         act_q <= trip_i | (act_q & ~zero_i);
  end

  assign active_o = act_q;
endmodule

// File: rtl/trip_int_ctrl.sv
module trip_int_ctrl #(
  parameter int NUM_SRC = pwm_trip_pkg::NUM_SRC
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_SRC-1:0] src_flag_i,
  input  logic [NUM_SRC-1:0] src_en_i,
  input  logic               clr_i,
  output logic               int_flag_o,
  output logic               pulse_o
);
  logic int_q;
  logic fire;

  assign fire = ~int_q & |(src_flag_i & src_en_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) int_q <= 1'b0;
    else         int_q <= fire | (int_q & ~clr_i);
  end

  assign int_flag_o = int_q;
  assign pulse_o    = fire;
endmodule

// File: rtl/pwm_trip_flags.sv
module pwm_trip_flags
  import pwm_trip_pkg::*;
#(
  parameter int FW = FLAG_W,
  parameter int CW = CLR_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          ost_trip_i,
  input  logic          cbc_trip_i,
  input  logic          ctr_zero_i,
  input  logic          ost_int_en_i,
  input  logic          cbc_int_en_i,
  input  logic          clr_we_i,
  input  logic [CW-1:0] clr_mask_i,
  output logic [FW-1:0] flags_o,
  output logic          int_pulse_o,
  output logic          ost_active_o,
  output logic          cbc_active_o
);
  logic [CW-1:0]      clr_hit;
  logic [NUM_SRC-1:0] src_set;
  logic [NUM_SRC-1:0] src_flag;
  logic [NUM_SRC-1:0] src_en;
  logic               int_flag;

  assign clr_hit          = clr_we_i ? clr_mask_i : '0;
  assign src_set[SRC_CBC] = cbc_trip_i;
  assign src_set[SRC_OST] = ost_trip_i;
  assign src_en[SRC_CBC]  = cbc_int_en_i;
  assign src_en[SRC_OST]  = ost_int_en_i;

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
    trip_flag_cell u_flag (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .set_i  (src_set[g]),
      .clr_i  (clr_hit[g+1]),
      .q_o    (src_flag[g])
    );
  end

  cbc_cond_hold u_cbc_hold (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .trip_i   (cbc_trip_i),
    .zero_i   (ctr_zero_i),
    .active_o (cbc_active_o)
  );

  trip_int_ctrl #(.NUM_SRC(NUM_SRC)) u_int (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .src_flag_i (src_flag),
    .src_en_i   (src_en),
    .clr_i      (clr_hit[BIT_INT]),
    .int_flag_o (int_flag),
    .pulse_o    (int_pulse_o)
  );

  always_comb begin
    flags_o          = '0;
    flags_o[BIT_INT] = int_flag;
    flags_o[BIT_CBC] = src_flag[SRC_CBC];
    flags_o[BIT_OST] = src_flag[SRC_OST];
  end

  assign ost_active_o = src_flag[SRC_OST];
endmodule

// File: rtl/pwm_trip_flags_chk.sv
module pwm_trip_flags_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        ost_trip_i,
  input logic        cbc_trip_i,
  input logic        ctr_zero_i,
  input logic        ost_int_en_i,
  input logic        cbc_int_en_i,
  input logic        clr_we_i,
  input logic [2:0]  clr_mask_i,
  input logic [15:0] flags_o,
  input logic        int_pulse_o,
  input logic        ost_active_o,
  input logic        cbc_active_o
);
  a_r1_upper_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flags_o[15:3] == '0);

  a_r3_cbc_set_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cbc_trip_i |=> flags_o[1]);

  a_r2_ost_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ost_trip_i |=> flags_o[2]);

  a_r4_no_we_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clr_we_i |=> $past(flags_o[2]) ? flags_o[2] : 1'b1);

  a_r5_cbc_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cbc_active_o && !ctr_zero_i) |=> cbc_active_o);

  a_r6_ost_no_zero_release: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ost_active_o && !(clr_we_i && clr_mask_i[2])) |=> ost_active_o);

  a_r7_one_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int_pulse_o |=> (!int_pulse_o && flags_o[0]));

  a_r8_gated: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int_pulse_o |-> ((flags_o[2] && ost_int_en_i) || (flags_o[1] && cbc_int_en_i)));

  a_r9_blocked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flags_o[0] |-> !int_pulse_o);

  a_r10_refire: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!flags_o[0] && ((flags_o[2] && ost_int_en_i) || (flags_o[1] && cbc_int_en_i)))
      |-> int_pulse_o);
endmodule

bind pwm_trip_flags pwm_trip_flags_chk u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .ost_trip_i   (ost_trip_i),
  .cbc_trip_i   (cbc_trip_i),
  .ctr_zero_i   (ctr_zero_i),
  .ost_int_en_i (ost_int_en_i),
  .cbc_int_en_i (cbc_int_en_i),
  .clr_we_i     (clr_we_i),
  .clr_mask_i   (clr_mask_i),
  .flags_o      (flags_o),
  .int_pulse_o  (int_pulse_o),
  .ost_active_o (ost_active_o),
  .cbc_active_o (cbc_active_o)
);

// File: tb/tb_pwm_trip_flags.sv
module tb_pwm_trip_flags;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ost_trip = 1'b0, cbc_trip = 1'b0, ctr_zero = 1'b0;
  logic        ost_en = 1'b0, cbc_en = 1'b0, clr_we = 1'b0;
  logic [2:0]  clr_mask = 3'b000;
  logic [15:0] flags;
  logic        pulse, ost_act, cbc_act;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // reference state
  bit m_ost, m_cbc, m_int, m_cact;

  always #(CLK_PERIOD/2) clk = ~clk;

  pwm_trip_flags dut (
    .clk_i(clk), .rst_ni(rst_n), .ost_trip_i(ost_trip), .cbc_trip_i(cbc_trip),
    .ctr_zero_i(ctr_zero), .ost_int_en_i(ost_en), .cbc_int_en_i(cbc_en),
    .clr_we_i(clr_we), .clr_mask_i(clr_mask), .flags_o(flags),
    .int_pulse_o(pulse), .ost_active_o(ost_act), .cbc_active_o(cbc_act)
  );

  function automatic bit m_fire();
    return !m_int && ((m_ost && ost_en) || (m_cbc && cbc_en));
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_ost = 0; m_cbc = 0; m_int = 0; m_cact = 0;
    end else begin
      bit f;
      bit [2:0] c;
      f = m_fire();
      c = clr_we ? clr_mask : 3'b000;
      m_int  = f || (m_int && !c[0]);
      m_ost  = ost_trip || (m_ost && !c[2]);
      m_cbc  = cbc_trip || (m_cbc && !c[1]);
      m_cact = cbc_trip || (m_cact && !ctr_zero);
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", req, act, exp, $time);
    end
  endtask

  // per-cycle comparison against the reference model
  always @(negedge clk) if (rst_n) begin
    chk("R1 upper", int'(flags[15:3]), 0);
    chk("R2 ost flag", int'(flags[2]), int'(m_ost));
    chk("R3 cbc flag", int'(flags[1]), int'(m_cbc));
    chk("R7 int flag", int'(flags[0]), int'(m_int));
    chk("R7 pulse", int'(pulse), int'(m_fire()));
    chk("R5 cbc active", int'(cbc_act), int'(m_cact));
    chk("R6 ost active", int'(ost_act), int'(m_ost));
  end

  task automatic step(input int n = 1);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      #2;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    step(2);
    chk("R1 reset flags", int'(flags), 0);
    rst_n = 1'b1;
    step(1);
    chk("R1 after reset", int'(flags), 0);

    // cbc trip with interrupts disabled
    cbc_trip = 1; step(1);
    chk("R3 cbc set", int'(flags[1]), 1);
    chk("R5 active set", int'(cbc_act), 1);
    chk("R8 disabled no pulse", int'(pulse), 0);
    cbc_trip = 0; step(1);
    clr_we = 1; clr_mask = 3'b010; step(1);
    clr_we = 0;
    chk("R3 cbc cleared", int'(flags[1]), 0);
    chk("R5 clear keeps active", int'(cbc_act), 1);
    ctr_zero = 1; step(1);
    ctr_zero = 0;
    chk("R5 released at zero", int'(cbc_act), 0);

    // zero while trip present does not release
    cbc_trip = 1; ctr_zero = 1; step(2);
    chk("R5 zero with trip", int'(cbc_act), 1);
    ctr_zero = 0;
    clr_we = 1; clr_mask = 3'b010; step(1);
    chk("R11 cbc set wins", int'(flags[1]), 1);
    cbc_trip = 0; step(1);
    clr_we = 0;
    chk("R3 cbc clear", int'(flags[1]), 0);
    ctr_zero = 1; step(1); ctr_zero = 0;

    // interrupt path
    cbc_en = 1; cbc_trip = 1; step(1); cbc_trip = 0;
    chk("R7 pulse", int'(pulse), 1);
    step(1);
    chk("R7 single cycle", int'(pulse), 0);
    chk("R7 int flag", int'(flags[0]), 1);
    cbc_trip = 1; step(2); cbc_trip = 0;
    chk("R9 blocked", int'(pulse), 0);
    clr_we = 1; clr_mask = 3'b001; step(1); clr_we = 0;
    chk("R10 refire", int'(pulse), 1);
    step(1);
    chk("R10 refire single", int'(pulse), 0);
    clr_we = 1; clr_mask = 3'b111; step(1); clr_we = 0;
    chk("R10 all cleared", int'(flags), 0);
    chk("R10 no pulse", int'(pulse), 0);
    step(1);
    chk("R10 stays quiet", int'(pulse), 0);
    ctr_zero = 1; step(1); ctr_zero = 0;

    // one-shot path, enable off, ignored write
    ost_trip = 1; step(1); ost_trip = 0;
    chk("R2 ost set", int'(flags[2]), 1);
    chk("R8 ost disabled", int'(pulse), 0);
    clr_mask = 3'b111; step(1);
    chk("R4 no strobe ignored", int'(flags), 3'b100);
    ctr_zero = 1; step(1); ctr_zero = 0;
    chk("R6 no zero release", int'(ost_act), 1);
    ost_en = 1; #1;
    chk("R8 late enable pulse", int'(pulse), 1);
    step(1);
    chk("R7 int set", int'(flags[0]), 1);
    ost_trip = 1; clr_we = 1; clr_mask = 3'b101; step(1);
    ost_trip = 0; clr_we = 0;
    chk("R11 ost set wins", int'(flags[2]), 1);
    chk("R10 ost refire", int'(pulse), 1);
    clr_we = 1; clr_mask = 3'b100; step(1); clr_we = 0;
    chk("R4 only ost cleared", int'(flags), 3'b001);
    clr_we = 1; clr_mask = 3'b001; step(1); clr_we = 0;

    // random phase, checked by the model
    for (int i = 0; i < 2000; i++) begin
      ost_trip = ($urandom_range(0, 9) == 0);
      cbc_trip = ($urandom_range(0, 5) == 0);
      ctr_zero = ($urandom_range(0, 3) == 0);
      ost_en   = $urandom_range(0, 1);
      cbc_en   = $urandom_range(0, 1);
      clr_we   = ($urandom_range(0, 2) == 0);
      clr_mask = 3'($urandom_range(0, 7));
      step(1);
    end

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule